// File: doc/BRIEF.md
# Grouped four-bit pattern detector

This block watches a serial bit stream and cuts it into aligned, back-to-back groups of four bits. The first valid bit after reset opens a group. The fourth valid bit closes it, and the next valid bit opens a new one. When the bit that closes a group completes either 0101 or 1001 (first-arriving bit on the left), the detect flag is high for that cycle. The flag is a Mealy output: it is decoded from the present state and the bit on the input in the same cycle. Windows never overlap, so a match that straddles two groups is not reported.

The machine has seven reduced states. After reset it waits for the first bit. After one bit it knows that bit's value. After two bits it is either still able to match or already ruled out. After three bits the same two cases hold. Prefixes 01 and 10 share one live state, and 00 and 11 share one dead state that only counts out the rest of the group. A parameter selects a compact binary state register or a one-hot register with one flip-flop per state. A state code that is not legal for the chosen encoding returns to the start state on the next valid bit.

Top module: `grp_det`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the machine in its start state. The next valid bit is then the first bit of a new group, and hit is 0 until a group completes.
- R2: hit is 1 during the fourth valid bit of a group when the group, in arrival order, reads 0,1,0,1.
- R3: hit is 1 during the fourth valid bit of a group when the group, in arrival order, reads 1,0,0,1.
- R4: For any of the other fourteen four-bit groups (for example 0100 and 1101), hit stays 0 through the whole group, including its fourth bit.
- R5: hit is 0 during the first, second and third valid bit of every group.
- R6: Groups do not overlap. After every fourth valid bit the machine returns to the start state, whatever the bits were, so a pattern that spans a group boundary is not detected.
- R7: While bit_vld is 0, hit is 0 and the state does not change, whatever the value of bit_in.
- R8: The encoding parameter ONE_HOT (0 = binary, 1 = one-hot, one flip-flop set in every state) has no effect on the behaviour at the ports.
- R9: A reset in the middle of a group discards the bits already received in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Detect flag, Mealy output, valid in the current cycle |

## Verification
The closing bit of one group and the opening bit of the next arrive on consecutive valid cycles. The second of these must land in the start state in the same edge that reports the first group's result. The bench provokes this with unbroken runs of matching groups, with shifted streams that put a pattern across a group boundary, and with idle cycles inserted just before a closing bit. A scoreboard tracks the group position and the bits received so far, and judges a binary and a one-hot instance against it on every cycle.

// File: rtl/grp_det_pkg.sv
package grp_det_pkg;

  localparam int unsigned GRP_NST = 7;

  typedef enum logic [2:0] {
    GS_IDLE  = 3'd0,
    GS_HEAD0 = 3'd1,
    GS_HEAD1 = 3'd2,
    GS_LIVE2 = 3'd3,
    GS_DEAD2 = 3'd4,
    GS_LIVE3 = 3'd5,
    GS_DEAD3 = 3'd6
  } grp_st_e;

endpackage

// File: rtl/grp_det_step.sv
module grp_det_step
  import grp_det_pkg::*;
(
  input  grp_st_e cur,
  input  logic    cur_ok,
  input  logic    x,
  output grp_st_e nxt,
  output logic    match
);

  always_comb begin
    nxt   = GS_IDLE;
    match = 1'b0;
    if (cur_ok) begin
      unique case (cur)
        GS_IDLE:  nxt = x ? GS_HEAD1 : GS_HEAD0;
        GS_HEAD0: nxt = x ? GS_LIVE2 : GS_DEAD2;
        GS_HEAD1: nxt = x ? GS_DEAD2 : GS_LIVE2;
        GS_LIVE2: nxt = x ? GS_DEAD3 : GS_LIVE3;
        GS_DEAD2: nxt = GS_DEAD3;
        GS_LIVE3: begin
          nxt   = GS_IDLE;
          match = x;
        end
        default:  nxt = GS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/grp_det_codec.sv
module grp_det_codec
  import grp_det_pkg::*;
#(
  parameter bit          ONE_HOT = 1'b0,
  parameter int unsigned SW      = 3
) (
  input  logic [SW-1:0] code,
  output grp_st_e       st,
  output logic          ok,
  input  grp_st_e       nst,
  output logic [SW-1:0] ncode
);

  generate
    if (ONE_HOT) begin : g_onehot
      always_comb begin
        st = GS_IDLE;
        for (int i = 0; i < int'(GRP_NST); i++) begin
          if (code[i]) st = grp_st_e'(3'(i));
        end
        ok    = ($countones(code) == 1);
        ncode = SW'(1) << nst;
      end
    end else begin : g_binary
      always_comb begin
        st    = grp_st_e'(code);
        ok    = (code < SW'(GRP_NST));
        ncode = SW'(nst);
      end
    end
  endgenerate

endmodule

// File: rtl/grp_det.sv
module grp_det
  import grp_det_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);

  localparam int unsigned SW = ONE_HOT ? GRP_NST : $clog2(GRP_NST);
  localparam logic [SW-1:0] RST_CODE = ONE_HOT ? SW'(1) : SW'(0);

  logic [SW-1:0] st_q;
  logic [SW-1:0] st_d;
  grp_st_e       cur_st;
  grp_st_e       nxt_st;
  logic          cur_ok;
  logic          step_match;

  grp_det_codec #(.ONE_HOT(ONE_HOT), .SW(SW)) u_codec (
    .code  (st_q),
    .st    (cur_st),
    .ok    (cur_ok),
    .nst   (nxt_st),
    .ncode (st_d)
  );

  grp_det_step u_step (
    .cur    (cur_st),
    .cur_ok (cur_ok),
    .x      (bit_in),
    .nxt    (nxt_st),
    .match  (step_match)
  );

  always_ff @(posedge clk) begin
    if (rst)          st_q <= RST_CODE;
    else if (bit_vld) st_q <= st_d;
  end

  assign hit = bit_vld & step_match;

endmodule

// File: rtl/grp_det_chk.sv
module grp_det_chk #(
  parameter bit          ONE_HOT = 1'b0,
  parameter int unsigned SW      = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          vld,
  input logic          x,
  input logic          hit,
  input logic [SW-1:0] st
);

  localparam logic [SW-1:0] START = ONE_HOT ? SW'(1) : SW'(0);

  logic [1:0] pos;
  logic [2:0] sh;
  logic [3:0] grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= 2'd0;
      sh  <= 3'd0;
    end else if (vld) begin
      pos <= pos + 2'd1;
      sh  <= {sh[1:0], x};
    end
  end

  assign grp = {sh, x};

  assert_reset_start_R1: assert property (@(posedge clk) rst |=> st == START);

  assert_match_R2: assert property (@(posedge clk) disable iff (rst)
    (vld && pos == 2'd3 && (grp == 4'b0101 || grp == 4'b1001)) |-> hit);

  assert_only_match_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> (grp == 4'b0101 || grp == 4'b1001));

  assert_pos_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> pos == 2'd3);

  assert_regroup_R6: assert property (@(posedge clk) disable iff (rst)
    (vld && pos == 2'd3) |=> st == START);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !vld |-> !hit);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(st));

  generate
    if (ONE_HOT) begin : g_oh
      assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);
    end
  endgenerate

endmodule

bind grp_det grp_det_chk #(.ONE_HOT(ONE_HOT), .SW(SW)) u_chk (
  .clk (clk),
  .rst (rst),
  .vld (bit_vld),
  .x   (bit_in),
  .hit (hit),
  .st  (st_q)
);

// File: tb/sim_grp_det.sv
module sim_grp_det;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic xin = 1'b0;
  logic z0, z1;

  int checks = 0;
  int bad    = 0;
  item_t q[$];

  int unsigned m_pos = 0;
  logic [2:0]  m_sh  = 3'd0;

  always #2 clk = ~clk;

  grp_det #(.ONE_HOT(1'b0)) u0 (.clk(clk), .rst(rst), .bit_vld(vld), .bit_in(xin), .hit(z0));
  grp_det #(.ONE_HOT(1'b1)) u1 (.clk(clk), .rst(rst), .bit_vld(vld), .bit_in(xin), .hit(z1));

  task automatic do_reset(int unsigned n);
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk);
      rst = 1'b1; vld = 1'b0; xin = 1'b0;
    end
    @(negedge clk);
    rst = 1'b0;
    m_pos = 0;
    m_sh  = 3'd0;
    q.push_back('{1'b0, "R1"});
  endtask

  task automatic send(logic v, logic b, string req);
    logic e;
    @(negedge clk);
    vld = v; xin = b;
    e = v && (m_pos == 3) && ({m_sh, b} == 4'b0101 || {m_sh, b} == 4'b1001);
    if (v) begin
      m_sh  = {m_sh[1:0], b};
      m_pos = (m_pos == 3) ? 0 : m_pos + 1;
    end
    q.push_back('{e, req});
  endtask

  task automatic send_grp(logic [3:0] g, string req);
    for (int i = 3; i >= 0; i--) send(1'b1, g[i], (i == 0) ? req : "R5");
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks += 2;
        if (z0 !== it.exp) begin
          bad++;
          $display("FAIL %s binary: hit=%b expected=%b", it.req, z0, it.exp);
        end
        if (z1 !== it.exp) begin
          bad++;
          $display("FAIL %s R8 one-hot: hit=%b expected=%b", it.req, z1, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : driver
    do_reset(2);
    send(1'b0, 1'b1, "R1");
    send(1'b0, 1'b0, "R1");
    send_grp(4'b0101, "R2");
    send_grp(4'b1001, "R3");
    send_grp(4'b0100, "R4");
    send_grp(4'b1101, "R4");
    for (int g = 0; g < 16; g++) send_grp(4'(g), (g == 5) ? "R2" : (g == 9) ? "R3" : "R4");
    // back-to-back matches, then a pattern across a boundary
    send_grp(4'b0101, "R6");
    send_grp(4'b0101, "R6");
    send(1'b1, 1'b1, "R6");
    send_grp(4'b0010, "R6");
    send(1'b1, 1'b1, "R6");
    send(1'b1, 1'b0, "R6");
    send(1'b1, 1'b0, "R6");
    // idle cycles inside a group with a matching bit on the input
    send(1'b1, 1'b0, "R7");
    send(1'b1, 1'b1, "R7");
    send(1'b1, 1'b0, "R7");
    send(1'b0, 1'b1, "R7");
    send(1'b0, 1'b1, "R7");
    send(1'b0, 1'b0, "R7");
    send(1'b1, 1'b1, "R7");
    // reset in mid-group
    send(1'b1, 1'b0, "R9");
    send(1'b1, 1'b1, "R9");
    do_reset(1);
    send_grp(4'b1001, "R9");
    // random stream
    for (int i = 0; i < 3000; i++) send(($urandom_range(3) != 0), $urandom_range(1) == 1, "R8");
    send(1'b0, 1'b0, "R8");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule